// File: doc/BRIEF.md
# Delay Line Bring-Up Sequencer

This block takes a programmable delay line from an unknown state to a locked, running state before any sampling-phase search starts. A single start pulse launches a fixed program of control changes. Clock gating for power saving is switched off first. The line is then placed in reset and power-down, and a 3-bit range code derived from the interface clock frequency is loaded while the line sits in that state. The line is released and enabled, and its output clock is switched on last. The block then samples the line's lock flag at a fixed interval and reports either success or a timeout.

All control outputs are plain levels and all status outputs are plain pulses or levels. There is no data stream, so no valid/ready handshake is involved. The frequency input is captured when start is accepted, so the caller may change it freely afterwards. The sampling interval, expressed in clock cycles, and the number of lock samples are parameters. With the defaults, a 100 MHz clock gives 50 samples spaced 1 µs apart.

Top module: `dll_bringup_seq`

## Requirements
- R1: In the cycle after start is accepted, `pwrsave_dis_o` is high, and it stays high afterwards. No other control output changes in that cycle.
- R2: Counting t from the edge that accepts start (t=0), exactly one step is applied per edge, in this order:
  - t=1: reset goes high, and enable and clock-output are cleared.
  - t=2: power-down goes high.
  - t=3: the range code is loaded.
  - t=4: reset goes low.
  - t=5: power-down goes low.
  - t=6: enable goes high.
  - t=7: clock-output enable goes high.
- R3: The range code is the smallest index i for which the frequency is at or below the bound for bin i. The bounds are 112, 125, 137, 150, 162, 175, 187 and 200 MHz for codes 0 to 7, and every comparison is inclusive.
- R4: A frequency above 200 MHz gives code 0.
- R5: `lock_i` is sampled at t = 8 + j·POLL_INTERVAL for j = 0 … POLL_LIMIT−1. On the first sample that sees lock high, `done_o` is high for exactly one cycle, starting at the next edge.
- R6: If none of the POLL_LIMIT samples sees lock, `timeout_o` pulses for one cycle in place of done, aligned to the last sample.
- R7: `busy_o` rises together with the power-save disable and falls in the same cycle that done or timeout is raised.
- R8: A start request while busy is ignored. The step timing, the outputs and the completion cycle are unchanged.
- R9: After reset, every output is low and the range code is 0.
- R10: The frequency is captured when start is accepted. Changes on `clk_freq_hz_i` while busy do not affect the loaded code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to run the bring-up program |
| clk_freq_hz_i | input | 32 | Interface clock frequency in Hz |
| lock_i | input | 1 | Lock flag from the delay line |
| pwrsave_dis_o | output | 1 | Disables clock gating for power saving |
| dll_rst_o | output | 1 | Delay line reset |
| dll_pdn_o | output | 1 | Delay line power-down |
| dll_en_o | output | 1 | Delay line enable |
| ck_out_en_o | output | 1 | Delay line output clock enable |
| freq_code_o | output | 3 | Frequency range code |
| busy_o | output | 1 | Program in progress |
| done_o | output | 1 | One-cycle pulse when lock is seen |
| timeout_o | output | 1 | One-cycle pulse when lock is never seen |

## Verification
The bench first targets the inclusive bin edges: exactly 112 MHz, one hertz above it, exactly 200 MHz, one hertz above 200 MHz, and zero. A design that uses a strict comparison or saturates above the top bin would return the wrong code at these points. It also targets lock arriving exactly on the last sample versus one cycle after it. An off-by-one in the sample count would turn the first case into a timeout, or would report done one interval late.

Every control output is compared on every cycle of every run, so a swapped or merged step shows up as a level mismatch. A start pulse is injected mid-run to catch a design that restarts. The frequency input is changed after acceptance to catch a design that bins the live input instead of the captured value.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;

  localparam int CODE_W   = 3;
  localparam int NUM_BINS = 1 << CODE_W;
  localparam int FREQ_W   = 32;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_ON,
    ST_PDN_ON,
    ST_CODE,
    ST_RST_OFF,
    ST_PDN_OFF,
    ST_EN_ON,
    ST_CKOUT_ON,
    ST_WAIT
  } seq_state_e;

  // Inclusive upper bound, in Hz, of each frequency bin.
  function automatic logic [FREQ_W-1:0] bin_limit_hz(input int idx);
    case (idx)
      0:       bin_limit_hz = 32'd112_000_000;
      1:       bin_limit_hz = 32'd125_000_000;
      2:       bin_limit_hz = 32'd137_000_000;
      3:       bin_limit_hz = 32'd150_000_000;
      4:       bin_limit_hz = 32'd162_000_000;
      5:       bin_limit_hz = 32'd175_000_000;
      6:       bin_limit_hz = 32'd187_000_000;
      default: bin_limit_hz = 32'd200_000_000;
    endcase
  endfunction

endpackage

// File: rtl/dll_freq_binner.sv
module dll_freq_binner
  import dll_seq_pkg::*;
(
  input  logic [FREQ_W-1:0] freq_i,
  output logic [CODE_W-1:0] code_o
);

  logic [NUM_BINS-1:0] at_or_below;

  genvar g;
  generate
    for (g = 0; g < NUM_BINS; g++) begin : g_cmp
      assign at_or_below[g] = (freq_i <= bin_limit_hz(g));
    end
  endgenerate

  // Lowest matching bin wins; no match (above top bound) stays at 0.
  always_comb begin
    code_o = '0;
    for (int i = NUM_BINS - 1; i >= 0; i--) begin
      if (at_or_below[i]) code_o = CODE_W'(i);
    end
  end

  // R3
  always_comb begin
    code_range_chk: assert (!(at_or_below[0] && code_o != '0));
  end

endmodule

// File: rtl/dll_lock_poller.sv
module dll_lock_poller #(
  parameter int POLL_INTERVAL = 100,
  parameter int POLL_LIMIT    = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic lock_i,
  output logic hit_o,
  output logic expire_o
);

  localparam int TICK_W = (POLL_INTERVAL > 1) ? $clog2(POLL_INTERVAL) : 1;
  localparam int CNT_W  = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(POLL_INTERVAL - 1);
  localparam logic [CNT_W-1:0]  POLL_LAST = CNT_W'(POLL_LIMIT - 1);

  logic              active_q;
  logic [TICK_W-1:0] tick_q;
  logic [CNT_W-1:0]  polls_q;
  logic              sample;

  assign sample   = active_q && (tick_q == '0);
  assign hit_o    = sample && lock_i;
  assign expire_o = sample && !lock_i && (polls_q == POLL_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      tick_q   <= '0;
      polls_q  <= '0;
    end else if (arm_i) begin
      active_q <= 1'b1;
      tick_q   <= '0;
      polls_q  <= '0;
    end else if (active_q) begin
      if (hit_o || expire_o) begin
        active_q <= 1'b0;
      end else begin
        if (sample) polls_q <= polls_q + 1'b1;
        tick_q <= (tick_q == TICK_LAST) ? '0 : tick_q + 1'b1;
      end
    end
  end

  // R6
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (polls_q <= POLL_LAST));

  // R5
  idle_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o && !arm_i) |=> !active_q);

endmodule

// File: rtl/dll_step_seq.sv
module dll_step_seq
  import dll_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [CODE_W-1:0] bin_code_i,
  input  logic              hit_i,
  input  logic              expire_i,
  output logic              arm_o,
  output logic [FREQ_W-1:0] freq_q_o,
  output logic              pwrsave_dis_o,
  output logic              dll_rst_o,
  output logic              dll_pdn_o,
  output logic              dll_en_o,
  output logic              ck_out_en_o,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);

  seq_state_e st_q;

  assign arm_o = (st_q == ST_CKOUT_ON);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      freq_q_o      <= '0;
      pwrsave_dis_o <= 1'b0;
      dll_rst_o     <= 1'b0;
      dll_pdn_o     <= 1'b0;
      dll_en_o      <= 1'b0;
      ck_out_en_o   <= 1'b0;
      code_o        <= '0;
      busy_o        <= 1'b0;
      done_o        <= 1'b0;
      timeout_o     <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          freq_q_o      <= freq_i;
          pwrsave_dis_o <= 1'b1;
          busy_o        <= 1'b1;
          st_q          <= ST_RST_ON;
        end
        ST_RST_ON: begin
          dll_rst_o   <= 1'b1;
          dll_en_o    <= 1'b0;
          ck_out_en_o <= 1'b0;
          st_q        <= ST_PDN_ON;
        end
        ST_PDN_ON: begin
          dll_pdn_o <= 1'b1;
          st_q      <= ST_CODE;
        end
        ST_CODE: begin
          code_o <= bin_code_i;
          st_q   <= ST_RST_OFF;
        end
        ST_RST_OFF: begin
          dll_rst_o <= 1'b0;
          st_q      <= ST_PDN_OFF;
        end
        ST_PDN_OFF: begin
          dll_pdn_o <= 1'b0;
          st_q      <= ST_EN_ON;
        end
        ST_EN_ON: begin
          dll_en_o <= 1'b1;
          st_q     <= ST_CKOUT_ON;
        end
        ST_CKOUT_ON: begin
          ck_out_en_o <= 1'b1;
          st_q        <= ST_WAIT;
        end
        ST_WAIT: begin
          if (hit_i) begin
            done_o <= 1'b1;
            busy_o <= 1'b0;
            st_q   <= ST_IDLE;
          end else if (expire_i) begin
            timeout_o <= 1'b1;
            busy_o    <= 1'b0;
            st_q      <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  pwrsave_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_rst_o) |-> pwrsave_dis_o);

  // R2
  rst_under_pdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dll_rst_o) |-> dll_pdn_o);

  // R2
  ckout_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ck_out_en_o) |-> (dll_en_o && !dll_rst_o && !dll_pdn_o));

  // R3
  code_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_o) |-> (dll_rst_o && dll_pdn_o));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  end_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || timeout_o) |-> (!busy_o && $past(busy_o)));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && start_i) |=> !dll_rst_o);

endmodule

// File: rtl/dll_bringup_seq.sv
module dll_bringup_seq
  import dll_seq_pkg::*;
#(
  parameter int POLL_INTERVAL = 100,
  parameter int POLL_LIMIT    = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       clk_freq_hz_i,
  input  logic              lock_i,
  output logic              pwrsave_dis_o,
  output logic              dll_rst_o,
  output logic              dll_pdn_o,
  output logic              dll_en_o,
  output logic              ck_out_en_o,
  output logic [2:0]        freq_code_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o
);

  logic [FREQ_W-1:0] freq_q;
  logic [CODE_W-1:0] bin_code;
  logic              arm;
  logic              hit;
  logic              expire;

  dll_freq_binner u_binner (
    .freq_i (freq_q),
    .code_o (bin_code)
  );

  dll_lock_poller #(
    .POLL_INTERVAL (POLL_INTERVAL),
    .POLL_LIMIT    (POLL_LIMIT)
  ) u_poller (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm),
    .lock_i   (lock_i),
    .hit_o    (hit),
    .expire_o (expire)
  );

  dll_step_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .freq_i        (clk_freq_hz_i),
    .bin_code_i    (bin_code),
    .hit_i         (hit),
    .expire_i      (expire),
    .arm_o         (arm),
    .freq_q_o      (freq_q),
    .pwrsave_dis_o (pwrsave_dis_o),
    .dll_rst_o     (dll_rst_o),
    .dll_pdn_o     (dll_pdn_o),
    .dll_en_o      (dll_en_o),
    .ck_out_en_o   (ck_out_en_o),
    .code_o        (freq_code_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .timeout_o     (timeout_o)
  );

  // R6
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && timeout_o));

  // R5
  done_needs_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ck_out_en_o && dll_en_o));

endmodule

// File: tb/dll_bringup_seq_test.sv
module dll_bringup_seq_test;

  localparam int PERIOD = 10;
  localparam int PI     = 5;
  localparam int PL     = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] clk_freq = '0;
  logic        lock;
  logic        pwrsave_dis, dll_rst, dll_pdn, dll_en, ck_out_en;
  logic [2:0]  freq_code;
  logic        busy, done, timeout;

  int checks = 0;
  int errors = 0;
  int cur_t = 0;
  int lock_delay = 0;
  int lock_cnt = 0;
  logic       prev_en = 1'b0;
  logic       prev_ck = 1'b0;
  logic [2:0] prev_code = 3'd0;

  always #(PERIOD/2) clk = ~clk;

  // Delay line model: lock rises lock_delay cycles after the output clock is enabled.
  always @(posedge clk) lock_cnt <= ck_out_en ? lock_cnt + 1 : 0;
  assign lock = ck_out_en && (lock_cnt >= lock_delay);

  dll_bringup_seq #(.POLL_INTERVAL(PI), .POLL_LIMIT(PL)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .clk_freq_hz_i(clk_freq),
    .lock_i(lock), .pwrsave_dis_o(pwrsave_dis), .dll_rst_o(dll_rst),
    .dll_pdn_o(dll_pdn), .dll_en_o(dll_en), .ck_out_en_o(ck_out_en),
    .freq_code_o(freq_code), .busy_o(busy), .done_o(done), .timeout_o(timeout)
  );

  function automatic logic [2:0] ref_bin(input logic [31:0] f);
    if (f <= 32'd112_000_000) return 3'd0;
    if (f <= 32'd125_000_000) return 3'd1;
    if (f <= 32'd137_000_000) return 3'd2;
    if (f <= 32'd150_000_000) return 3'd3;
    if (f <= 32'd162_000_000) return 3'd4;
    if (f <= 32'd175_000_000) return 3'd5;
    if (f <= 32'd187_000_000) return 3'd6;
    if (f <= 32'd200_000_000) return 3'd7;
    return 3'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", tag, cur_t, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] f, input int d, input int poke_t, input logic change_f);
    logic [2:0] ecode;
    int j, endt;
    logic hit;
    ecode = ref_bin(f);
    j = (d + PI - 1) / PI;
    hit = (j <= PL - 1);
    endt = hit ? 8 + j * PI : 8 + (PL - 1) * PI;
    @(negedge clk);
    clk_freq = f; lock_delay = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t <= endt + 1; t++) begin
      if (t > 0) @(negedge clk);
      cur_t = t;
      check("R1 pwrsave", {31'd0, pwrsave_dis}, 32'd1);
      check("R2 reset", {31'd0, dll_rst}, {31'd0, (t >= 1 && t <= 3)});
      check("R2 powerdown", {31'd0, dll_pdn}, {31'd0, (t >= 2 && t <= 4)});
      check("R2 enable", {31'd0, dll_en}, {31'd0, (t == 0) ? prev_en : (t >= 6)});
      check("R2 ckout", {31'd0, ck_out_en}, {31'd0, (t == 0) ? prev_ck : (t >= 7)});
      check("R3 R4 R10 code", {29'd0, freq_code}, {29'd0, (t >= 3) ? ecode : prev_code});
      check("R7 busy", {31'd0, busy}, {31'd0, (t < endt)});
      check("R5 done", {31'd0, done}, {31'd0, (t == endt) && hit});
      check("R6 timeout", {31'd0, timeout}, {31'd0, (t == endt) && !hit});
      if (t == 1 && change_f) clk_freq = $urandom;
      start = (t == poke_t); // R8 start during busy
    end
    start = 1'b0;
    prev_en = 1'b1; prev_ck = 1'b1; prev_code = ecode;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 reset outs", {23'd0, pwrsave_dis, dll_rst, dll_pdn, dll_en, ck_out_en,
                            busy, done, timeout, 1'b0},
          32'd0);
    check("R9 reset code", {29'd0, freq_code}, 32'd0);
    // R3 / R4 boundaries, R5 immediate lock
    run(32'd112_000_000, 0, -1, 1'b0);
    run(32'd112_000_001, 1, -1, 1'b0);
    run(32'd200_000_000, 3, -1, 1'b0);
    run(32'd200_000_001, 0, -1, 1'b0);   // R4
    run(32'd0, 2, -1, 1'b0);
    run(32'd150_000_000, PI * (PL - 1), -1, 1'b0);      // R5 lock on last sample
    run(32'd137_000_001, PI * (PL - 1) + 1, -1, 1'b0);  // R6 timeout
    run(32'd175_000_000, 1000, 4, 1'b1);  // R6 no lock, R8 poke, R10 freq change
    run(32'd187_000_000, 7, 12, 1'b1);    // R8 poke while waiting
    for (int n = 0; n < 25; n++) begin
      logic [31:0] f;
      int d, p;
      f = $urandom_range(260_000_000, 0);
      d = $urandom_range(PI * PL + 3, 0);
      p = $urandom_range(9, 0);
      run(f, d, p, n[0]);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule